// File: doc/BRIEF.md
# Mixed-Precision Integer Matrix Multiply-Accumulate Unit

This unit performs one small integer matrix multiply-accumulate per accepted input. Two 256-bit operand words each carry a matrix with four rows. The column count follows from the element width. An accumulator bus of up to 1024 bits supplies the running sums, and a one-bit mode input picks the arithmetic.

In the byte mode, the unit treats both operands as 4×8 arrays of signed bytes. It multiplies the left array by the transpose of the right one, so each of the sixteen 32-bit sums gains an eight-term dot product between a left row and a right row. That is 128 multiply-accumulates per operation. In the halfword mode, the unit treats both operands as 4×4 arrays of signed 16-bit values. It forms the ordinary matrix product into sixteen 64-bit sums, which is 64 multiply-accumulates per operation.

The updated accumulator is registered and appears one clock after the input is accepted. It stays unchanged until the next accepted input. Register-file access and instruction scheduling belong to the surrounding datapath.

Top module: `imac_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `acc_out` is all zeros. Reset acts without waiting for a clock edge.
- R2: With `mode`=0 (byte mode), element (i,k) of each operand is the signed byte at bits [8·(8i+k) +: 8], for i in 0..3 and k in 0..7. Sum (i,j) sits at bits [32·(4i+j) +: 32] of `acc_in` and of `acc_out`. The new value is acc(i,j) + Σk A(i,k)·B(j,k), so the right operand enters transposed.
- R3: In byte mode, each 32-bit sum is two's-complement and wraps modulo 2^32, with no saturation.
- R4: In byte mode, bits [1023:512] of `acc_out` are zero. Bits [1023:512] of `acc_in` have no effect on the result.
- R5: With `mode`=1 (halfword mode), element (r,c) of each operand is the signed 16-bit value at bits [16·(4r+c) +: 16]. Sum (i,j) sits at bits [64·(4i+j) +: 64]. The new value is acc(i,j) + Σk A(i,k)·B(k,j).
- R6: In halfword mode, each 64-bit sum is two's-complement and wraps modulo 2^64, with no saturation.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The matching result is on `acc_out` in that same cycle. Back-to-back inputs produce back-to-back results.
- R8: While `in_valid` is low, `acc_out` keeps its value and the operand, accumulator and mode inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the operands this cycle |
| mode | input | 1 | 0: signed byte with 32-bit sums; 1: signed halfword with 64-bit sums |
| opa | input | 256 | Left operand word |
| opb | input | 256 | Right operand word |
| acc_in | input | 1024 | Accumulator sums before the operation |
| out_valid | output | 1 | Result on `acc_out` is new this cycle |
| acc_out | output | 1024 | Updated accumulator sums |

## Verification
The unit holds no state beyond the output register, so any internal fault shows up on `acc_out` in the cycle right after the input that triggered it. A lane wired to the wrong right-operand row or column corrupts a predictable subset of the sixteen sums. A sign-extension slip appears only when negative elements are present, and a wrong sum width appears only at wrap-around. The directed vectors therefore use all-ones, identity and extreme-value operands, next to random words checked against a bench model. A broken capture enable shows up as a changed `acc_out` during idle cycles, or as a stale value after a back-to-back pair.

// File: rtl/imac_pkg.sv
package imac_pkg;
  // Geometry shared by all lanes
  localparam int ROWS      = 4;
  localparam int B_COLS    = 8;           // columns of a byte-mode operand
  localparam int B_EW      = 8;           // byte element width
  localparam int H_EW      = 16;          // halfword element width
  localparam int B_AW      = 32;          // byte-mode sum width
  localparam int H_AW      = 64;          // halfword-mode sum width
  localparam int H_COLS    = ROWS;        // columns of a halfword operand
  localparam int OP_W      = ROWS * B_COLS * B_EW;
  localparam int B_ACC_W   = ROWS * ROWS * B_AW;
  localparam int H_ACC_W   = ROWS * ROWS * H_AW;
  localparam int ACC_W     = H_ACC_W;

  typedef enum logic {
    MODE_BYTE = 1'b0,
    MODE_HALF = 1'b1
  } imac_mode_e;
endpackage

// File: rtl/imac_dot.sv
// One accumulator lane: acc + sum over N signed element products.
module imac_dot #(
  parameter int EW = 8,
  parameter int N  = 8,
  parameter int AW = 32
) (
  input  logic [N*EW-1:0] a_vec,
  input  logic [N*EW-1:0] b_vec,
  input  logic [AW-1:0]   acc,
  output logic [AW-1:0]   sum
);
  localparam int PW = 2 * EW;

  logic [AW-1:0] acc_w;

  always_comb begin
    logic signed [PW-1:0] ax;
    logic signed [PW-1:0] bx;
    logic signed [PW-1:0] prod;
    acc_w = acc;
    for (int k = 0; k < N; k++) begin
      ax    = {{EW{a_vec[k*EW+EW-1]}}, a_vec[k*EW +: EW]};
      bx    = {{EW{b_vec[k*EW+EW-1]}}, b_vec[k*EW +: EW]};
      prod  = ax * bx;
      acc_w = acc_w + {{(AW-PW){prod[PW-1]}}, prod};
    end
  end

  assign sum = acc_w;
endmodule

// File: rtl/imac_byte_array.sv
// Byte mode: sixteen lanes, right operand rows act as result columns.
module imac_byte_array #(
  parameter int ROWS = imac_pkg::ROWS,
  parameter int COLS = imac_pkg::B_COLS,
  parameter int EW   = imac_pkg::B_EW,
  parameter int AW   = imac_pkg::B_AW
) (
  input  logic [ROWS*COLS*EW-1:0] opa,
  input  logic [ROWS*COLS*EW-1:0] opb,
  input  logic [ROWS*ROWS*AW-1:0] acc_in,
  output logic [ROWS*ROWS*AW-1:0] res
);
  localparam int ROW_W = COLS * EW;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < ROWS; j++) begin : g_col
      imac_dot #(.EW(EW), .N(COLS), .AW(AW)) u_lane (
        .a_vec (opa[i*ROW_W +: ROW_W]),
        .b_vec (opb[j*ROW_W +: ROW_W]),
        .acc   (acc_in[(i*ROWS+j)*AW +: AW]),
        .sum   (res[(i*ROWS+j)*AW +: AW])
      );
    end
  end

  // A zero right operand must leave every sum untouched (R2)
  always_comb begin
    if (opb == '0) begin
      assert_zero_rhs_keeps_acc_R2: assert (res == acc_in);
    end
  end
endmodule

// File: rtl/imac_half_array.sv
// Halfword mode: sixteen lanes, right operand columns gathered per lane.
module imac_half_array #(
  parameter int ROWS = imac_pkg::ROWS,
  parameter int EW   = imac_pkg::H_EW,
  parameter int AW   = imac_pkg::H_AW
) (
  input  logic [ROWS*ROWS*EW-1:0] opa,
  input  logic [ROWS*ROWS*EW-1:0] opb,
  input  logic [ROWS*ROWS*AW-1:0] acc_in,
  output logic [ROWS*ROWS*AW-1:0] res
);
  localparam int ROW_W = ROWS * EW;

  // Column-major copy of the right operand
  logic [ROWS*ROWS*EW-1:0] b_cols;

  for (genvar j = 0; j < ROWS; j++) begin : g_gather
    for (genvar k = 0; k < ROWS; k++) begin : g_elem
      assign b_cols[(j*ROWS+k)*EW +: EW] = opb[(k*ROWS+j)*EW +: EW];
    end
  end

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < ROWS; j++) begin : g_col
      imac_dot #(.EW(EW), .N(ROWS), .AW(AW)) u_lane (
        .a_vec (opa[i*ROW_W +: ROW_W]),
        .b_vec (b_cols[j*ROW_W +: ROW_W]),
        .acc   (acc_in[(i*ROWS+j)*AW +: AW]),
        .sum   (res[(i*ROWS+j)*AW +: AW])
      );
    end
  end

  // A zero left operand must leave every sum untouched (R5)
  always_comb begin
    if (opa == '0) begin
      assert_zero_lhs_keeps_acc_R5: assert (res == acc_in);
    end
  end
endmodule

// File: rtl/imac_unit.sv
module imac_unit
  import imac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             mode,
  input  logic [OP_W-1:0]  opa,
  input  logic [OP_W-1:0]  opb,
  input  logic [ACC_W-1:0] acc_in,
  output logic             out_valid,
  output logic [ACC_W-1:0] acc_out
);
  logic [B_ACC_W-1:0] byte_res;
  logic [H_ACC_W-1:0] half_res;
  logic [ACC_W-1:0]   acc_d;
  logic [ACC_W-1:0]   acc_q;
  logic               vld_q;
  logic               mode_q;
  imac_mode_e         mode_sel;

  assign mode_sel = imac_mode_e'(mode);

  imac_byte_array #(
    .ROWS (ROWS), .COLS (B_COLS), .EW (B_EW), .AW (B_AW)
  ) u_byte (
    .opa    (opa),
    .opb    (opb),
    .acc_in (acc_in[B_ACC_W-1:0]),
    .res    (byte_res)
  );

  imac_half_array #(
    .ROWS (ROWS), .EW (H_EW), .AW (H_AW)
  ) u_half (
    .opa    (opa),
    .opb    (opb),
    .acc_in (acc_in[H_ACC_W-1:0]),
    .res    (half_res)
  );

  // Next-state selection
  always_comb begin
    acc_d = acc_q;
    if (in_valid) begin
      if (mode_sel == MODE_BYTE) acc_d = {{(ACC_W-B_ACC_W){1'b0}}, byte_res};
      else                       acc_d = half_res;
    end
  end

  // Result register with explicit capture enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      vld_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        acc_q  <= acc_d;
        mode_q <= mode;
      end
    end
  end

  assign acc_out   = acc_q;
  assign out_valid = vld_q;

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_out));
  assert_byte_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q == 1'b0) |-> (acc_out[ACC_W-1:B_ACC_W] == '0));
endmodule

// File: tb/sim_imac_unit.sv
`timescale 1ns/1ps
module sim_imac_unit;
  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          mode;
  logic [255:0]  opa, opb;
  logic [1023:0] acc_in;
  logic          out_valid;
  logic [1023:0] acc_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  imac_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .opa(opa), .opb(opb), .acc_in(acc_in),
    .out_valid(out_valid), .acc_out(acc_out)
  );

  // Bench models taken from the requirement formulas
  function automatic logic [1023:0] m_byte(input logic [255:0] a, input logic [255:0] b,
                                           input logic [1023:0] acc);
    logic [1023:0] r = '0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        logic [31:0] s = acc[32*(4*i+j) +: 32];
        for (int k = 0; k < 8; k++) begin
          logic signed [31:0] x, y;
          x = $signed(a[8*(8*i+k) +: 8]);
          y = $signed(b[8*(8*j+k) +: 8]);
          s = s + 32'(x * y);
        end
        r[32*(4*i+j) +: 32] = s;
      end
    return r;
  endfunction

  function automatic logic [1023:0] m_half(input logic [255:0] a, input logic [255:0] b,
                                           input logic [1023:0] acc);
    logic [1023:0] r = '0;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        logic [63:0] s = acc[64*(4*i+j) +: 64];
        for (int k = 0; k < 4; k++) begin
          logic signed [63:0] x, y;
          x = $signed(a[16*(4*i+k) +: 16]);
          y = $signed(b[16*(4*k+j) +: 16]);
          s = s + 64'(x * y);
        end
        r[64*(4*i+j) +: 64] = s;
      end
    return r;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int w = 0; w < 8; w++) v[32*w +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [1023:0] rnd1024();
    logic [1023:0] v;
    for (int w = 0; w < 32; w++) v[32*w +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string req, input logic [1023:0] act, input logic [1023:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one input cycle; return with the result visible (after the capturing edge)
  task automatic apply(input logic m, input logic [255:0] a, input logic [255:0] b,
                       input logic [1023:0] acc);
    @(negedge clk);
    in_valid = 1'b1; mode = m; opa = a; opb = b; acc_in = acc;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 out_valid", {1023'd0, out_valid}, 1024'd1);
  endtask

  task automatic t_reset();
    check("R1 reset valid", {1023'd0, out_valid}, 1024'd0);
    check("R1 reset acc", acc_out, '0);
  endtask

  task automatic t_byte_ones();
    logic [1023:0] e = '0;
    for (int n = 0; n < 16; n++) e[32*n +: 32] = 32'd8;
    apply(1'b0, {32{8'h01}}, {32{8'h01}}, '0);
    check("R2 all-ones bytes", acc_out, e);
  endtask

  task automatic t_byte_random();
    for (int t = 0; t < 6; t++) begin
      logic [255:0] a = rnd256(), b = rnd256();
      logic [1023:0] c = rnd1024();
      apply(1'b0, a, b, c);
      check("R2 random bytes", acc_out, m_byte(a, b, c));
    end
  endtask

  task automatic t_byte_transpose();
    // Right operand row j all ones except row 0 zero: column 0 keeps acc
    logic [255:0] a = rnd256();
    logic [255:0] b = {{24{8'h01}}, {8{8'h00}}};
    logic [1023:0] c = rnd1024();
    apply(1'b0, a, b, c);
    check("R2 transposed rhs", acc_out, m_byte(a, b, c));
    for (int i = 0; i < 4; i++)
      check("R2 zero rhs row keeps column", {992'd0, acc_out[32*(4*i) +: 32]},
            {992'd0, c[32*(4*i) +: 32]});
  endtask

  task automatic t_byte_wrap();
    logic [1023:0] c = '0;
    logic [1023:0] e = '0;
    for (int n = 0; n < 16; n++) begin
      c[32*n +: 32] = 32'h7FFF_FFFF;
      e[32*n +: 32] = 32'h8001_FFFF;
    end
    apply(1'b0, {32{8'h80}}, {32{8'h80}}, c);
    check("R3 byte wrap", acc_out, e);
  endtask

  task automatic t_byte_upper();
    logic [255:0] a = rnd256(), b = rnd256();
    logic [1023:0] c = rnd1024();
    apply(1'b0, a, b, c);
    check("R4 upper half zero", {512'd0, acc_out[1023:512]}, '0);
    check("R4 upper acc_in ignored", acc_out, m_byte(a, b, {512'd0, c[511:0]}));
  endtask

  task automatic t_half_identity();
    logic [255:0] id = '0;
    logic [255:0] b = rnd256();
    logic [1023:0] c = rnd1024();
    logic [1023:0] e;
    for (int d = 0; d < 4; d++) id[16*(5*d) +: 16] = 16'd1;
    for (int n = 0; n < 16; n++)
      e[64*n +: 64] = c[64*n +: 64] + {{48{b[16*n+15]}}, b[16*n +: 16]};
    apply(1'b1, id, b, c);
    check("R5 identity lhs", acc_out, e);
  endtask

  task automatic t_half_random();
    for (int t = 0; t < 6; t++) begin
      logic [255:0] a = rnd256(), b = rnd256();
      logic [1023:0] c = rnd1024();
      apply(1'b1, a, b, c);
      check("R5 random halfwords", acc_out, m_half(a, b, c));
    end
  endtask

  task automatic t_half_wrap();
    logic [1023:0] c, e;
    for (int n = 0; n < 16; n++) begin
      c[64*n +: 64] = 64'h7FFF_FFFF_FFFF_FFFF;
      e[64*n +: 64] = 64'h8000_0000_FFFF_FFFF;
    end
    apply(1'b1, {16{16'h8000}}, {16{16'h8000}}, c);
    check("R6 halfword wrap", acc_out, e);
  endtask

  task automatic t_back_to_back();
    logic [255:0] a0 = rnd256(), b0 = rnd256(), a1 = rnd256(), b1 = rnd256();
    logic [1023:0] c0 = rnd1024(), c1 = rnd1024();
    @(negedge clk);
    in_valid = 1'b1; mode = 1'b0; opa = a0; opb = b0; acc_in = c0;
    @(negedge clk);
    check("R7 first of pair valid", {1023'd0, out_valid}, 1024'd1);
    check("R7 first of pair data", acc_out, m_byte(a0, b0, c0));
    mode = 1'b1; opa = a1; opb = b1; acc_in = c1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 second of pair valid", {1023'd0, out_valid}, 1024'd1);
    check("R7 second of pair data", acc_out, m_half(a1, b1, c1));
    @(negedge clk);
    check("R7 valid drops", {1023'd0, out_valid}, 1024'd0);
  endtask

  task automatic t_hold();
    logic [255:0] a = rnd256(), b = rnd256();
    logic [1023:0] c = rnd1024();
    logic [1023:0] e;
    apply(1'b1, a, b, c);
    e = m_half(a, b, c);
    opa = rnd256(); opb = rnd256(); acc_in = rnd1024(); mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 idle hold data", acc_out, e);
    check("R8 idle no valid", {1023'd0, out_valid}, 1024'd0);
  endtask

  task automatic t_async_reset();
    apply(1'b0, rnd256(), rnd256(), rnd1024());
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async clear", acc_out, '0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 cleared valid", {1023'd0, out_valid}, 1024'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; mode = 1'b0;
    opa = '0; opb = '0; acc_in = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_byte_ones();
    t_byte_random();
    t_byte_transpose();
    t_byte_wrap();
    t_byte_upper();
    t_half_identity();
    t_half_random();
    t_half_wrap();
    t_back_to_back();
    t_hold();
    t_async_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule